// File: doc/BRIEF.md
# VMEbus Slave to Host-Port Handshake Bridge

This block lets a VMEbus master read and write a local graphics processor through the processor's host port. An upstream decoder flags that the current VMEbus address belongs to this board. Once a data strobe falls, the bridge drives the processor's chip-select together with either its write strobe or its read strobe. It holds them until the processor reports ready, or until a fixed timeout expires. It moves 32-bit data in the direction the VMEbus WRITE line asks for and acknowledges the master with DTACK. It keeps DTACK asserted until the master has released both data strobes, which completes a four-phase handshake between two unrelated clock domains.

The bridge also serves block transfers. When the address-modifier code marks a block cycle, the master presents one start address and then runs as many data cycles as it likes under a single address strobe. The bridge provides the host address itself and advances it one long word after each completed cycle, with no upper bound on the run length. Every VMEbus control input and the processor's ready line arrive asynchronously, so each passes through a two-stage synchronizer before the sequencer uses it.

Top module: `vme_host_bridge`

## Requirements
- R1: The address strobe, both data strobes, WRITE, the board-select input and host ready are each resynchronised through two flip-flops. Host chip-select therefore falls on the third rising clock edge after a request is set up at the pins: address strobe low, select high, and at least one data strobe low.
- R2: During a host access, host_cs_n is low. Exactly one of host_rd_n or host_wr_n is low, chosen by WRITE: vme_write_n low selects the write strobe, high selects the read strobe. The two host strobes are never low together, and neither is low while host_cs_n is high.
- R3: The host strobes stay asserted until the synchronised host ready is seen. With the responder asserting ready on its (d+1)-th sample of a low chip-select, chip-select stays low for exactly d+3 clock cycles.
- R4: On a read, the host data present when ready is sampled is captured and driven on vme_data_out, with vme_data_oe high, for the whole time DTACK is asserted. It stays unchanged during that time.
- R5: On a write, vme_data_in is captured when the request is accepted and presented on host_wdata. It and host_addr stay constant while chip-select is low.
- R6: DTACK goes low in the same cycle the host strobes are released after ready. It stays low while either data strobe is still asserted, and goes high only after both strobes are high. vme_data_oe is never high while DTACK is high.
- R7: The address-modifier codes 0x0B, 0x0F, 0x3B and 0x3F mark block mode. In block mode host_addr advances by 4 after each completed cycle, wrapping modulo 2^32. For all other codes, host_addr holds the start address for every cycle under the same address strobe.
- R8: A block run accepts any number of consecutive data cycles under one address strobe, including runs longer than 64 long words, and keeps advancing the address.
- R9: Each new falling edge of the address strobe reloads host_addr from vme_addr and re-evaluates block mode from vme_am.
- R10: If host ready is not seen within TIMEOUT_CYC cycles of chip-select falling, the strobes are released after exactly TIMEOUT_CYC low cycles. DTACK is not asserted, the address does not advance, and the bridge accepts a new cycle once both data strobes have been high.
- R11: While rst_n is low, all host strobes and DTACK are high and vme_data_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vme_as_n | input | 1 | VMEbus address strobe, asynchronous |
| vme_ds0_n | input | 1 | VMEbus data strobe 0, asynchronous |
| vme_ds1_n | input | 1 | VMEbus data strobe 1, asynchronous |
| vme_write_n | input | 1 | VMEbus direction, low means write |
| vme_sel | input | 1 | Board selected by upstream address decode |
| vme_am | input | 6 | Address-modifier code |
| vme_addr | input | 32 | Start address, sampled on address strobe fall |
| vme_data_in | input | 32 | Write data from the master |
| vme_data_out | output | 32 | Read data toward the master |
| vme_data_oe | output | 1 | Drive enable for read data transceivers |
| vme_dtack_n | output | 1 | Data transfer acknowledge |
| host_cs_n | output | 1 | Host port chip-select |
| host_wr_n | output | 1 | Host port write strobe |
| host_rd_n | output | 1 | Host port read strobe |
| host_addr | output | 32 | Host port address |
| host_wdata | output | 32 | Host port write data |
| host_rdata | input | 32 | Host port read data |
| host_rdy | input | 1 | Host ready response, asynchronous |

## Verification
The processor model's response delay is swept from zero to eight samples, for both reads and writes, with walking-one, walking-zero and all-zero/all-one data. The exact chip-select width separates correct ready synchronisation from an off-by-one stage or a missed wait. All 64 address-modifier codes are each run with two cycles under one address strobe, which tells the four block codes apart from every other code. A 70-beat block run that starts near the top of the address space shows that there is no length cap and that the address wraps. A second address strobe in mid-run shows the reload. Releasing one data strobe before the other distinguishes a DTACK release that needs both strobes from one that needs only either. A silent processor exercises the timeout and the recovery that follows it.

// File: rtl/vhb_pkg.sv
// Package vhb_pkg
// Shared types for the VMEbus-to-host-port bridge: sequencer state
// encoding and the block-mode address-modifier decode.
package vhb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_REPLY   = 2'd2,
        ST_RECOVER = 2'd3
    } vhb_state_e;

    localparam int AM_W = 6;

    // True for the four address-modifier codes that request block transfers
    function automatic logic is_block_am(input logic [AM_W-1:0] am);
        return (am == 6'h0B) || (am == 6'h0F) || (am == 6'h3B) || (am == 6'h3F);
    endfunction

endpackage

// File: rtl/vhb_sync.sv
// Module vhb_sync
// Two-stage synchroniser, one independent pair of flops per bit.
// Assumes each bit is an unrelated level; no bus coherency is implied.
// RST_VAL gives the inactive level each bit takes during reset.
module vhb_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Purpose: capture the asynchronous level, then let it settle one more cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end

        assign q[i] = stab_q;
    end

endmodule

// File: rtl/vhb_addr_ctr.sv
// Module vhb_addr_ctr
// Host address generator. A load takes priority over a step. A step adds
// STEP and wraps modulo 2^AW. Assumes load_val is stable when load is high.
module vhb_addr_ctr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] addr_q;

    // Purpose: reload on a new address strobe, otherwise advance after a completed beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            addr_q <= addr_q + STEP_V;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/vhb_cycle_fsm.sv
// Module vhb_cycle_fsm
// Four-phase cycle sequencer: idle -> host strobe -> reply (DTACK) -> idle.
// It has a timeout path through a recovery state that waits for the
// data strobes to be released. All inputs must already be synchronised.
module vhb_cycle_fsm
    import vhb_pkg::*;
#(
    parameter int TIMEOUT_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,        // address strobe, select and a data strobe all active
    input  logic       ds_idle,    // both data strobes released
    input  logic       host_rdy,
    output vhb_state_e state,
    output logic       accept,     // request taken this cycle
    output logic       capture,    // host answered this cycle
    output logic       complete    // handshake finished this cycle
);

    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

    vhb_state_e      state_q, state_d;
    logic [TO_W-1:0] wait_q;

    // Purpose: next-state decode for the handshake sequence
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_STROBE;
                    accept  = 1'b1;
                end
            end
            ST_STROBE: begin
                if (host_rdy) begin
                    state_d = ST_REPLY;
                    capture = 1'b1;
                end else if (wait_q == TO_LAST) begin
                    state_d = ST_RECOVER;
                end
            end
            ST_REPLY: begin
                if (ds_idle) begin
                    state_d  = ST_IDLE;
                    complete = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (ds_idle) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Purpose: count cycles spent waiting for the host, cleared outside the strobe phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (state_q == ST_STROBE) begin
            wait_q <= wait_q + 1'b1;
        end else begin
            wait_q <= '0;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/vme_host_bridge.sv
// Module vme_host_bridge
// Bridges VMEbus slave data cycles onto a processor host port.
// Assumes: upstream decode drives vme_sel; vme_addr and vme_am are stable
// for at least three clocks after the address strobe falls; vme_data_in is
// stable for three clocks after a data strobe falls; host_rdata is valid
// whenever host_rdy is high.
module vme_host_bridge
    import vhb_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int TIMEOUT_CYC = 32,
    parameter int ADDR_STEP   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vme_as_n,
    input  logic          vme_ds0_n,
    input  logic          vme_ds1_n,
    input  logic          vme_write_n,
    input  logic          vme_sel,
    input  logic [5:0]    vme_am,
    input  logic [AW-1:0] vme_addr,
    input  logic [DW-1:0] vme_data_in,
    output logic [DW-1:0] vme_data_out,
    output logic          vme_data_oe,
    output logic          vme_dtack_n,
    output logic          host_cs_n,
    output logic          host_wr_n,
    output logic          host_rd_n,
    output logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] host_rdata,
    input  logic          host_rdy
);

    localparam int          NSYNC    = 5;
    localparam logic [4:0]  SYNC_RST = 5'b01111;  // sel inactive low, strobes inactive high

    logic [NSYNC-1:0] sync_in, sync_out;
    logic             as_s, ds0_s, ds1_s, write_n_s, sel_s;
    logic             rdy_s;
    logic             as_prev_q;
    logic             as_fall;
    logic             block_q;
    logic             dir_wr_q;
    logic [DW-1:0]    rdata_q;
    logic [DW-1:0]    wdata_q;
    logic             req, ds_idle;
    logic             accept, capture, complete;
    vhb_state_e       state;

    assign sync_in = {vme_sel, vme_write_n, vme_ds1_n, vme_ds0_n, vme_as_n};

    vhb_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync_vme (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    vhb_sync #(.W(1), .RST_VAL(1'b0)) u_sync_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (host_rdy),
        .q     (rdy_s)
    );

    assign as_s      = sync_out[0];
    assign ds0_s     = sync_out[1];
    assign ds1_s     = sync_out[2];
    assign write_n_s = sync_out[3];
    assign sel_s     = sync_out[4];

    assign req     = !as_s && sel_s && (!ds0_s || !ds1_s);
    assign ds_idle = ds0_s && ds1_s;
    assign as_fall = as_prev_q && !as_s;

    // Purpose: remember the previous address strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_prev_q <= 1'b1;
        end else begin
            as_prev_q <= as_s;
        end
    end

    // Purpose: latch block mode from the address modifier at each address strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q <= 1'b0;
        end else if (as_fall) begin
            block_q <= is_block_am(vme_am);
        end
    end

    vhb_cycle_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .ds_idle  (ds_idle),
        .host_rdy (rdy_s),
        .state    (state),
        .accept   (accept),
        .capture  (capture),
        .complete (complete)
    );

    vhb_addr_ctr #(.AW(AW), .STEP(ADDR_STEP)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (as_fall),
        .load_val (vme_addr),
        .step     (complete && block_q),
        .addr     (host_addr)
    );

    // Purpose: capture direction and write data when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_wr_q <= 1'b0;
            wdata_q  <= '0;
        end else if (accept) begin
            dir_wr_q <= !write_n_s;
            wdata_q  <= vme_data_in;
        end
    end

    // Purpose: capture host read data when the processor answers a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture && !dir_wr_q) begin
            rdata_q <= host_rdata;
        end
    end

    // Purpose: decode pin levels from the sequencer state
    always_comb begin
        host_cs_n   = !(state == ST_STROBE);
        host_wr_n   = !(state == ST_STROBE && dir_wr_q);
        host_rd_n   = !(state == ST_STROBE && !dir_wr_q);
        vme_dtack_n = !(state == ST_REPLY);
        vme_data_oe = (state == ST_REPLY) && !dir_wr_q;
    end

    assign vme_data_out = rdata_q;
    assign host_wdata   = wdata_q;

endmodule

// File: rtl/vhb_checker.sv
// Module vhb_checker
// Protocol properties for vme_host_bridge, attached with bind.
// Observes ports only and keeps one private counter for the timeout window.
module vhb_checker #(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int TIMEOUT_CYC = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vme_ds0_n,
    input logic          vme_ds1_n,
    input logic          vme_dtack_n,
    input logic          vme_data_oe,
    input logic [DW-1:0] vme_data_out,
    input logic          host_cs_n,
    input logic          host_wr_n,
    input logic          host_rd_n,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] host_wdata
);

    localparam int CW = $clog2(TIMEOUT_CYC + 2);

    logic [CW-1:0] cs_low_cnt;

    // Purpose: count consecutive cycles with chip-select low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_low_cnt <= '0;
        end else if (!host_cs_n) begin
            cs_low_cnt <= cs_low_cnt + 1'b1;
        end else begin
            cs_low_cnt <= '0;
        end
    end

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!host_wr_n && !host_rd_n));

    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr_n || !host_rd_n) |-> !host_cs_n);

    p_dtack_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vme_dtack_n |-> host_cs_n);

    p_dtack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vme_dtack_n) |-> $past(vme_ds0_n && vme_ds1_n, 2));

    p_oe_in_dtack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vme_data_oe |-> !vme_dtack_n);

    p_hold_during_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs_n && $past(!host_cs_n)) |-> ($stable(host_addr) && $stable(host_wdata)));

    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!vme_dtack_n && $past(!vme_dtack_n)) |-> $stable(vme_data_out));

    p_timeout_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_low_cnt <= CW'(TIMEOUT_CYC));

endmodule

bind vme_host_bridge vhb_checker #(
    .DW          (DW),
    .AW          (AW),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vme_ds0_n    (vme_ds0_n),
    .vme_ds1_n    (vme_ds1_n),
    .vme_dtack_n  (vme_dtack_n),
    .vme_data_oe  (vme_data_oe),
    .vme_data_out (vme_data_out),
    .host_cs_n    (host_cs_n),
    .host_wr_n    (host_wr_n),
    .host_rd_n    (host_rd_n),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata)
);

// File: tb/vme_host_bridge_tb.sv
// Bench for vme_host_bridge: a master driven by tasks and a processor model
// with a programmable ready delay. Inputs change and outputs are sampled
// 1 ns after the falling clock edge.
module vme_host_bridge_tb;

    localparam int TO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vme_as_n = 1'b1, vme_ds0_n = 1'b1, vme_ds1_n = 1'b1;
    logic        vme_write_n = 1'b1, vme_sel = 1'b0;
    logic [5:0]  vme_am = '0;
    logic [31:0] vme_addr = '0, vme_data_in = '0;
    logic [31:0] vme_data_out;
    logic        vme_data_oe, vme_dtack_n;
    logic        host_cs_n, host_wr_n, host_rd_n;
    logic [31:0] host_addr, host_wdata;
    logic [31:0] host_rdata = '0;
    logic        host_rdy = 1'b0;

    int tests = 0;
    int fails = 0;
    int rsp_delay = 0;
    bit rsp_en = 1'b1;
    int cs_cnt = 0;
    int last_low = 0;

    always #2 clk = ~clk;

    vme_host_bridge #(.TIMEOUT_CYC(TO)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .vme_as_n (vme_as_n), .vme_ds0_n (vme_ds0_n), .vme_ds1_n (vme_ds1_n),
        .vme_write_n (vme_write_n), .vme_sel (vme_sel), .vme_am (vme_am),
        .vme_addr (vme_addr), .vme_data_in (vme_data_in),
        .vme_data_out (vme_data_out), .vme_data_oe (vme_data_oe),
        .vme_dtack_n (vme_dtack_n), .host_cs_n (host_cs_n),
        .host_wr_n (host_wr_n), .host_rd_n (host_rd_n),
        .host_addr (host_addr), .host_wdata (host_wdata),
        .host_rdata (host_rdata), .host_rdy (host_rdy)
    );

    function automatic logic [31:0] rd_pat(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic bit blk_am(input logic [5:0] am);
        return am == 6'h0B || am == 6'h0F || am == 6'h3B || am == 6'h3F;
    endfunction

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Processor model: raises ready after a chosen number of low chip-select samples
    initial begin
        forever begin
            @(negedge clk);
            if (!host_cs_n) begin
                if (rsp_en && cs_cnt >= rsp_delay) begin
                    host_rdy   = 1'b1;
                    host_rdata = rd_pat(host_addr);
                end
                cs_cnt++;
                last_low = cs_cnt;
            end else begin
                cs_cnt   = 0;
                host_rdy = 1'b0;
            end
        end
    end

    task automatic start_as(input logic [5:0] am, input logic [31:0] a);
        vme_am   = am;
        vme_addr = a;
        vme_sel  = 1'b1;
        vme_as_n = 1'b0;
        repeat (4) tick();
    endtask

    task automatic end_as();
        vme_as_n = 1'b1;
        vme_sel  = 1'b0;
        repeat (4) tick();
    endtask

    task automatic do_cycle(input bit wr, input logic [31:0] wd, input int dly,
                            input logic [31:0] ea, input bit lat);
        int n;
        rsp_delay   = dly;
        vme_write_n = !wr;
        vme_data_in = wd;
        vme_ds0_n   = 1'b0;
        vme_ds1_n   = 1'b0;
        if (lat) begin
            tick(); tick();
            chk(host_cs_n == 1'b1, "R1", "cs before 3rd edge", 32'(host_cs_n), 32'h1);
            tick();
            chk(host_cs_n == 1'b0, "R1", "cs at 3rd edge", 32'(host_cs_n), 32'h0);
        end
        n = 0;
        while (host_cs_n && n < 40) begin tick(); n++; end
        chk(!host_cs_n && (host_wr_n == !wr) && (host_rd_n == wr), "R2", "strobes",
            {29'h0, host_cs_n, host_wr_n, host_rd_n}, {29'h0, 1'b0, !wr, wr});
        chk(host_addr == ea, "R7", "host address", host_addr, ea);
        if (wr) chk(host_wdata == wd, "R5", "write data", host_wdata, wd);
        n = 0;
        while (!host_cs_n && n < 100) begin tick(); n++; end
        chk(last_low == dly + 3, "R3", "cs low cycles", 32'(last_low), 32'(dly + 3));
        chk(vme_dtack_n == 1'b0, "R6", "dtack on reply", 32'(vme_dtack_n), 32'h0);
        if (!wr)
            chk(vme_data_oe && vme_data_out == rd_pat(ea), "R4", "read data",
                vme_data_out, rd_pat(ea));
        else
            chk(vme_data_oe == 1'b0, "R4", "oe on write", 32'(vme_data_oe), 32'h0);
        vme_ds0_n = 1'b1;
        repeat (5) tick();
        chk(vme_dtack_n == 1'b0, "R6", "dtack with one ds", 32'(vme_dtack_n), 32'h0);
        vme_ds1_n = 1'b1;
        n = 0;
        while (!vme_dtack_n && n < 20) begin tick(); n++; end
        chk(vme_dtack_n && !vme_data_oe, "R6", "dtack released",
            {30'h0, vme_dtack_n, vme_data_oe}, 32'h2);
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R11: reset state
        chk(host_cs_n && host_wr_n && host_rd_n && vme_dtack_n && !vme_data_oe, "R11",
            "reset outputs", {27'h0, host_cs_n, host_wr_n, host_rd_n, vme_dtack_n, vme_data_oe},
            32'h1E);
        rst_n = 1'b1;
        repeat (2) tick();

        // R1 latency, then R2-R6 sweep over delay, direction and data
        start_as(6'h09, 32'h0000_1000);
        do_cycle(1'b1, 32'hCAFE_F00D, 0, 32'h0000_1000, 1'b1);
        for (int d = 0; d <= 8; d++) begin
            do_cycle(1'b1, 32'h1 << (d * 3), d, 32'h0000_1000, 1'b0);
            do_cycle(1'b1, ~(32'h1 << (d * 3)), d, 32'h0000_1000, 1'b0);
            do_cycle(1'b0, 32'h0, d, 32'h0000_1000, 1'b0);
            do_cycle(1'b1, (d % 2) ? 32'hFFFF_FFFF : 32'h0, d, 32'h0000_1000, 1'b0);
        end
        end_as();

        // R7: every address-modifier code, two cycles under one strobe
        for (int am = 0; am < 64; am++) begin
            logic [31:0] base;
            base = 32'(am) << 8;
            start_as(6'(am), base);
            do_cycle(1'b1, base, 1, base, 1'b0);
            do_cycle(1'b0, 32'h0, 1, blk_am(6'(am)) ? base + 32'd4 : base, 1'b0);
            end_as();
        end

        // R8: long block run with wrap; R9: reload on a new strobe mid-run
        start_as(6'h0B, 32'hFFFF_FF80);
        for (int i = 0; i < 70; i++)
            do_cycle(i[0], 32'(i), i % 3, 32'hFFFF_FF80 + 32'(i * 4), 1'b0);
        vme_as_n = 1'b1;
        repeat (4) tick();
        vme_am   = 6'h3F;
        vme_addr = 32'h0040_0000;
        vme_as_n = 1'b0;
        repeat (4) tick();
        do_cycle(1'b0, 32'h0, 2, 32'h0040_0000, 1'b0);   // R9 reload
        do_cycle(1'b0, 32'h0, 2, 32'h0040_0004, 1'b0);   // R8 keeps stepping
        end_as();

        // R10: silent processor, timeout, then recovery
        start_as(6'h0F, 32'h0000_2000);
        begin
            int n;
            bit saw_dtack;
            rsp_en      = 1'b0;
            vme_write_n = 1'b1;
            vme_ds0_n   = 1'b0;
            vme_ds1_n   = 1'b0;
            saw_dtack   = 1'b0;
            n = 0;
            while (host_cs_n && n < 40) begin tick(); n++; end
            n = 0;
            while (!host_cs_n && n < 100) begin
                tick(); n++;
                if (!vme_dtack_n) saw_dtack = 1'b1;
            end
            chk(last_low == TO, "R10", "cs low at timeout", 32'(last_low), 32'(TO));
            repeat (6) begin
                tick();
                if (!vme_dtack_n) saw_dtack = 1'b1;
            end
            chk(!saw_dtack && host_cs_n, "R10", "no dtack after timeout",
                32'(saw_dtack), 32'h0);
            vme_ds0_n = 1'b1;
            vme_ds1_n = 1'b1;
            repeat (5) tick();
            rsp_en = 1'b1;
        end
        do_cycle(1'b0, 32'h0, 3, 32'h0000_2000, 1'b0);   // R10 no step, works again
        do_cycle(1'b1, 32'h1234_5678, 0, 32'h0000_2004, 1'b0);
        end_as();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule